// File: doc/BRIEF.md
# ATM Cell Header Error Check and Correction

This block examines the five-octet header of every delineated ATM cell. It recomputes the header error control (HEC) octet, and either repairs a single-bit error or flags the cell as errored. A small two-state machine chooses between a correcting mode and a detecting mode, and configuration pins change how it behaves. A correcting pass is allowed only while the machine is in correcting mode. After an error the machine either drops into detecting mode or, if so configured, stays in correcting mode for as long as cell delineation holds.

Headers enter on a valid/ready stream, one whole header per beat. Each header leaves one cycle later on a valid/ready stream. The outgoing header carries the correction, if one was made, and a drop flag that a later stage uses to discard the cell. The source holds `in_valid` and `in_hdr` until `in_ready` is seen high at a clock edge. The sink can stall with `out_ready` low. While it does, the output beat is held and `in_ready` falls, so back-pressure reaches the source without any buffering in between. Per-cell event pulses drive two saturating 16-bit counters, one for errored headers and one for corrected headers. Each counter raises a level interrupt while its count is above a programmable threshold.

Top module: `atm_hec_check`

## Requirements
- R1: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. A header accepted at a clock edge appears on `out_valid`/`out_hdr`/`out_drop` after that edge. While `out_valid` is high and `out_ready` is low, the output beat stays unchanged.
- R2: Header bits [39:8] are octets 1 to 4, most significant bit first, and bits [7:0] are the received HEC. The expected HEC is the CRC-8 of bits [39:8] with generator x^8+x^2+x+1 and a zero start value, XORed with `cfg_coset`. A mismatch, when checking is enabled, is an HEC error and pulses `hec_err_pulse` for one cycle after acceptance.
- R3: In correcting mode, with `cfg_correct_en` high, a header whose mismatch matches one of the 40 single-bit error patterns leaves with that bit inverted. `hec_cor_pulse` pulses and `out_drop` is 0.
- R4: With `cfg_correct_en` low, a single-bit error is not repaired. It is handled like an uncorrectable error.
- R5: An uncorrected errored header leaves unchanged with `out_drop` equal to `cfg_drop_errored`. Clean and corrected headers always have `out_drop` 0.
- R6: With `cfg_stay_correct` low, any HEC error moves the machine to detecting mode. In detecting mode no correction is made, and a clean header returns the machine to correcting mode.
- R7: With `cfg_stay_correct` high, the machine stays in correcting mode after errors. Whenever `cell_sync` is low, the machine is forced to correcting mode.
- R8: With `cfg_detect_en` low, headers pass unchanged, with no event pulses, `out_drop` 0, and no change of mode.
- R9: `cnt_hec` counts HEC errors and `cnt_cor` counts corrections. Each counts at the edge where the header is accepted, stops at 16'hFFFF, and does not count while `loopback` is high.
- R10: `irq_hec` is high while `cnt_hec` > `thr_hec`, and `irq_cor` is high while `cnt_cor` > `thr_cor`.
- R11: After reset, `out_valid`, both pulses and both counters are 0, and the machine is in correcting mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Header beat valid |
| in_ready | output | 1 | Block can accept a header |
| in_hdr | input | 40 | Received header, octet 1 in [39:32], HEC in [7:0] |
| out_valid | output | 1 | Checked header valid |
| out_ready | input | 1 | Sink accepts the output beat |
| out_hdr | output | 40 | Header after optional correction |
| out_drop | output | 1 | Cell should be discarded |
| cell_sync | input | 1 | Cell delineation is in its locked state |
| cfg_detect_en | input | 1 | Enable HEC checking |
| cfg_correct_en | input | 1 | Enable single-bit correction |
| cfg_stay_correct | input | 1 | Remain in correcting mode after errors |
| cfg_drop_errored | input | 1 | Mark uncorrected errored cells for discard |
| cfg_coset | input | 8 | Coset XORed into the HEC |
| loopback | input | 1 | Receive loopback active, counters frozen |
| thr_hec | input | 16 | Threshold for the error counter |
| thr_cor | input | 16 | Threshold for the correction counter |
| hec_err_pulse | output | 1 | One-cycle pulse per errored header |
| hec_cor_pulse | output | 1 | One-cycle pulse per corrected header |
| cnt_hec | output | 16 | Saturating HEC error count |
| cnt_cor | output | 16 | Saturating correction count |
| irq_hec | output | 1 | Error count above threshold |
| irq_cor | output | 1 | Correction count above threshold |

## Verification
The properties assume that the configuration pins and `cell_sync` hold their values across the edge where a header is taken, and that `out_ready` is never unknown after reset. The stimulus changes configuration only between cells, at the falling edge, while no beat is being offered. It drives `out_ready` from the same task that offers headers, so every handshake is settled well before the rising edge. Under back-pressure the properties check only the held output beat. They make no assumption about how long the sink stalls.

// File: rtl/hec_pkg.sv
package hec_pkg;
  localparam int HDR_W   = 40;
  localparam int DATA_W  = 32;
  localparam int HEC_W   = 8;
  localparam logic [HEC_W-1:0] GEN_POLY = 8'h07;

  typedef enum logic {MODE_CORR = 1'b0, MODE_DET = 1'b1} hec_mode_e;

  // CRC-8 over the four leading octets, MSB first, zero start value
  function automatic logic [HEC_W-1:0] crc8_of(logic [DATA_W-1:0] d);
    logic [HEC_W-1:0] c;
    logic fb;
    c = '0;
    for (int b = DATA_W - 1; b >= 0; b--) begin
      fb = c[HEC_W-1] ^ d[b];
      c  = {c[HEC_W-2:0], 1'b0} ^ (fb ? GEN_POLY : '0);
    end
    return c;
  endfunction

  // Mismatch pattern caused by inverting header bit p
  function automatic logic [HEC_W-1:0] syn_of_pos(int p);
    logic [DATA_W-1:0] e;
    if (p < HEC_W) return HEC_W'(1) << p;
    e = DATA_W'(1) << (p - HEC_W);
    return crc8_of(e);
  endfunction
endpackage

// File: rtl/hec_syndrome.sv
module hec_syndrome
  import hec_pkg::*;
(
  input  logic [HDR_W-1:0] hdr,
  input  logic [HEC_W-1:0] coset,
  output logic             mismatch,
  output logic             single_hit,
  output logic [HDR_W-1:0] flip_mask
);
  logic [HEC_W-1:0] syn;

  assign syn      = crc8_of(hdr[HDR_W-1:HEC_W]) ^ coset ^ hdr[HEC_W-1:0];
  assign mismatch = |syn;

  for (genvar i = 0; i < HDR_W; i++) begin : g_pos
    localparam logic [HEC_W-1:0] SYN_I = syn_of_pos(i);
    assign flip_mask[i] = (syn == SYN_I);
  end

  assign single_hit = |flip_mask;
endmodule

// File: rtl/hec_mode_fsm.sv
module hec_mode_fsm
  import hec_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic sync_ok,
  input  logic detect_en,
  input  logic correct_en,
  input  logic stay_correct,
  input  logic drop_errored,
  input  logic mismatch,
  input  logic single_hit,
  output logic err_evt,
  output logic cor_evt,
  output logic drop_cell
);
  hec_mode_e mode_q, mode_d;

  always_comb begin
    err_evt   = 1'b0;
    cor_evt   = 1'b0;
    drop_cell = 1'b0;
    mode_d    = mode_q;
    if (detect_en) begin
      if (mismatch) begin
        err_evt = 1'b1;
        if (mode_q == MODE_CORR && correct_en && single_hit) cor_evt = 1'b1;
        else drop_cell = drop_errored;
        mode_d = stay_correct ? MODE_CORR : MODE_DET;
      end else begin
        mode_d = MODE_CORR;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= MODE_CORR;
    else if (!sync_ok) mode_q <= MODE_CORR;
    else if (step)    mode_q <= mode_d;
  end
endmodule

// File: rtl/hec_sat_counter.sv
module hec_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         freeze,
  input  logic [W-1:0] thr,
  output logic [W-1:0] count,
  output logic         irq
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else if (inc && !freeze && count != TOP) count <= count + W'(1);
  end

  assign irq = count > thr;
endmodule

// File: rtl/atm_hec_check.sv
module atm_hec_check
  import hec_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [HDR_W-1:0] in_hdr,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [HDR_W-1:0] out_hdr,
  output logic             out_drop,
  input  logic             cell_sync,
  input  logic             cfg_detect_en,
  input  logic             cfg_correct_en,
  input  logic             cfg_stay_correct,
  input  logic             cfg_drop_errored,
  input  logic [HEC_W-1:0] cfg_coset,
  input  logic             loopback,
  input  logic [CNT_W-1:0] thr_hec,
  input  logic [CNT_W-1:0] thr_cor,
  output logic             hec_err_pulse,
  output logic             hec_cor_pulse,
  output logic [CNT_W-1:0] cnt_hec,
  output logic [CNT_W-1:0] cnt_cor,
  output logic             irq_hec,
  output logic             irq_cor
);
  logic             take;
  logic             mismatch, single_hit;
  logic [HDR_W-1:0] flip_mask;
  logic             err_evt, cor_evt, drop_cell;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  hec_syndrome u_syn (
    .hdr        (in_hdr),
    .coset      (cfg_coset),
    .mismatch   (mismatch),
    .single_hit (single_hit),
    .flip_mask  (flip_mask)
  );

  hec_mode_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .step         (take),
    .sync_ok      (cell_sync),
    .detect_en    (cfg_detect_en),
    .correct_en   (cfg_correct_en),
    .stay_correct (cfg_stay_correct),
    .drop_errored (cfg_drop_errored),
    .mismatch     (mismatch),
    .single_hit   (single_hit),
    .err_evt      (err_evt),
    .cor_evt      (cor_evt),
    .drop_cell    (drop_cell)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_hdr       <= '0;
      out_drop      <= 1'b0;
      hec_err_pulse <= 1'b0;
      hec_cor_pulse <= 1'b0;
    end else begin
      hec_err_pulse <= take && err_evt;
      hec_cor_pulse <= take && cor_evt;
      if (take) begin
        out_valid <= 1'b1;
        out_hdr   <= in_hdr ^ (cor_evt ? flip_mask : '0);
        out_drop  <= drop_cell;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  hec_sat_counter #(.W(CNT_W)) u_cnt_err (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc    (take && err_evt),
    .freeze (loopback),
    .thr    (thr_hec),
    .count  (cnt_hec),
    .irq    (irq_hec)
  );

  hec_sat_counter #(.W(CNT_W)) u_cnt_cor (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc    (take && cor_evt),
    .freeze (loopback),
    .thr    (thr_cor),
    .count  (cnt_cor),
    .irq    (irq_cor)
  );
endmodule

// File: rtl/atm_hec_check_sva.sv
module atm_hec_check_sva #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [39:0]      out_hdr,
  input logic             out_drop,
  input logic             cfg_detect_en,
  input logic             cfg_drop_errored,
  input logic             loopback,
  input logic             hec_err_pulse,
  input logic             hec_cor_pulse,
  input logic [CNT_W-1:0] cnt_hec,
  input logic [CNT_W-1:0] cnt_cor,
  input logic             irq_hec
);
  // R1
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_hdr) && $stable(out_drop)));

  // R3
  cor_forwarded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hec_cor_pulse |-> (hec_err_pulse && out_valid && !out_drop));

  // R8
  check_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !cfg_detect_en) |=> (!hec_err_pulse && !hec_cor_pulse && !out_drop));

  // R5
  pass_errored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !cfg_drop_errored) |=> !out_drop);

  // R9
  err_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_hec >= $past(cnt_hec)) && (cnt_cor >= $past(cnt_cor)));

  // R9
  loop_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loopback |=> ($stable(cnt_hec) && $stable(cnt_cor)));

  // R10
  irq_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hec |-> (cnt_hec != '0));
endmodule

bind atm_hec_check atm_hec_check_sva #(.CNT_W(CNT_W)) u_sva (
  .clk              (clk),
  .rst_n            (rst_n),
  .in_valid         (in_valid),
  .in_ready         (in_ready),
  .out_valid        (out_valid),
  .out_ready        (out_ready),
  .out_hdr          (out_hdr),
  .out_drop         (out_drop),
  .cfg_detect_en    (cfg_detect_en),
  .cfg_drop_errored (cfg_drop_errored),
  .loopback         (loopback),
  .hec_err_pulse    (hec_err_pulse),
  .hec_cor_pulse    (hec_cor_pulse),
  .cnt_hec          (cnt_hec),
  .cnt_cor          (cnt_cor),
  .irq_hec          (irq_hec)
);

// File: tb/atm_hec_check_tb.sv
`timescale 1ns/1ps
module atm_hec_check_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [39:0] in_hdr = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [39:0] out_hdr;
  logic out_drop;
  logic cell_sync = 1'b1;
  logic cfg_detect_en = 1'b1, cfg_correct_en = 1'b1, cfg_stay_correct = 1'b0, cfg_drop_errored = 1'b1;
  logic [7:0] cfg_coset = 8'h55;
  logic loopback = 1'b0;
  logic [15:0] thr_hec = 16'd3, thr_cor = 16'd2;
  logic hec_err_pulse, hec_cor_pulse;
  logic [15:0] cnt_hec, cnt_cor;
  logic irq_hec, irq_cor;

  int vectors = 0;
  int errors = 0;
  int cycles = 0;
  logic started = 1'b0;
  logic bp = 1'b0;

  // reference state
  logic m_ov = 0, m_drop = 0, m_err = 0, m_cor = 0, m_det = 0;
  logic [39:0] m_hdr = '0;
  int m_chec = 0, m_ccor = 0;

  always #2.5 clk = ~clk;

  atm_hec_check u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_hdr(in_hdr),
    .out_valid(out_valid), .out_ready(out_ready), .out_hdr(out_hdr), .out_drop(out_drop),
    .cell_sync(cell_sync), .cfg_detect_en(cfg_detect_en), .cfg_correct_en(cfg_correct_en),
    .cfg_stay_correct(cfg_stay_correct), .cfg_drop_errored(cfg_drop_errored), .cfg_coset(cfg_coset),
    .loopback(loopback), .thr_hec(thr_hec), .thr_cor(thr_cor), .hec_err_pulse(hec_err_pulse),
    .hec_cor_pulse(hec_cor_pulse), .cnt_hec(cnt_hec), .cnt_cor(cnt_cor), .irq_hec(irq_hec), .irq_cor(irq_cor)
  );

  // polynomial remainder of {data, 8'h00} modulo 0x107
  function automatic logic [7:0] ref_hec(input logic [31:0] d);
    logic [39:0] r;
    r = {d, 8'h00};
    for (int i = 39; i >= 8; i--)
      if (r[i]) r = r ^ (40'h107 << (i - 8));
    return r[7:0];
  endfunction

  function automatic logic is_bad(input logic [39:0] h, input logic [7:0] cs);
    return (ref_hec(h[39:8]) ^ cs) != h[7:0];
  endfunction

  function automatic logic [39:0] mk(input logic [31:0] d, input logic [39:0] flips);
    return {d, ref_hec(d) ^ cfg_coset} ^ flips;
  endfunction

  function automatic logic [39:0] bit1(input int k);
    return 40'd1 << k;
  endfunction

  // cycle model
  always @(posedge clk) begin
    logic acc, bad, fixed, e, c, d, nd;
    logic [39:0] h;
    started <= 1'b1;
    if (!rst_n) begin
      m_ov = 0; m_hdr = '0; m_drop = 0; m_err = 0; m_cor = 0; m_det = 0; m_chec = 0; m_ccor = 0;
    end else begin
      acc = in_valid && (!m_ov || out_ready);
      nd = m_det;
      e = 0; c = 0; d = 0; h = in_hdr;
      if (acc) begin
        if (cfg_detect_en) begin
          bad = is_bad(in_hdr, cfg_coset);
          if (!bad) nd = 0;
          else begin
            e = 1;
            fixed = 0;
            if (!m_det && cfg_correct_en)
              for (int k = 0; k < 40; k++)
                if (!fixed && !is_bad(in_hdr ^ bit1(k), cfg_coset)) begin
                  fixed = 1; h = in_hdr ^ bit1(k);
                end
            if (fixed) c = 1; else d = cfg_drop_errored;
            nd = !cfg_stay_correct;
          end
        end
        m_ov = 1; m_hdr = h; m_drop = d;
        if (!loopback) begin
          if (e && m_chec < 65535) m_chec++;
          if (c && m_ccor < 65535) m_ccor++;
        end
      end else if (out_ready) m_ov = 0;
      m_err = e; m_cor = c;
      m_det = cell_sync ? nd : 1'b0;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (started) begin
      chk("R1 out_valid", 64'(out_valid), 64'(m_ov));
      chk("R1 in_ready", 64'(in_ready), 64'(!m_ov || out_ready));
      if (m_ov) begin
        chk("R3 out_hdr", 64'(out_hdr), 64'(m_hdr));
        chk("R5 out_drop", 64'(out_drop), 64'(m_drop));
      end
      chk("R2 hec_err_pulse", 64'(hec_err_pulse), 64'(m_err));
      chk("R3 hec_cor_pulse", 64'(hec_cor_pulse), 64'(m_cor));
      chk("R9 cnt_hec", 64'(cnt_hec), 64'(m_chec));
      chk("R9 cnt_cor", 64'(cnt_cor), 64'(m_ccor));
      chk("R10 irq_hec", 64'(irq_hec), 64'(m_chec > int'(thr_hec)));
      chk("R10 irq_cor", 64'(irq_cor), 64'(m_ccor > int'(thr_cor)));
    end
  end

  task automatic send(input logic [39:0] h);
    logic r;
    in_valid = 1'b1;
    in_hdr = h;
    forever begin
      if (bp) out_ready = 1'($urandom % 2);
      #1;
      r = in_ready;
      @(negedge clk);
      if (r) break;
    end
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    // R11: reset state observed while reset is held
    chk("R11 out_valid", 64'(out_valid), 64'd0);
    chk("R11 cnt_hec", 64'(cnt_hec), 64'd0);
    chk("R11 hec_err_pulse", 64'(hec_err_pulse), 64'd0);
    rst_n = 1'b1;
    idle(2);
    // R2: clean cells
    for (int i = 0; i < 6; i++) send(mk($urandom, '0));
    // R3 then R6: one corrected, next single-bit error detected and dropped, clean returns
    send(mk(32'h1234_5678, bit1(20)));
    send(mk(32'h0000_0001, bit1(3)));
    send(mk(32'hCAFE_0001, '0));
    send(mk(32'hCAFE_0002, bit1(39)));
    // R7: stay in correcting mode
    cfg_stay_correct = 1'b1;
    for (int k = 0; k < 40; k += 7) send(mk($urandom, bit1(k)));
    send(mk(32'hDEAD_BEEF, bit1(1) | bit1(30)));
    send(mk(32'hDEAD_BEF0, bit1(12)));
    // R4: correction disabled
    cfg_correct_en = 1'b0;
    send(mk(32'h0F0F_0F0F, bit1(9)));
    // R5: errored cells forwarded
    cfg_drop_errored = 1'b0;
    send(mk(32'h0F0F_0F10, bit1(33)));
    send(mk(32'h0F0F_0F11, bit1(2) | bit1(5)));
    cfg_correct_en = 1'b1;
    cfg_drop_errored = 1'b1;
    cfg_stay_correct = 1'b0;
    // R7: sync loss forces correcting mode
    send(mk(32'h1111_2222, bit1(17)));
    cell_sync = 1'b0;
    idle(1);
    cell_sync = 1'b1;
    send(mk(32'h1111_2223, bit1(18)));
    // R8: checking disabled
    cfg_detect_en = 1'b0;
    send(mk(32'h5555_AAAA, bit1(0) | bit1(8)));
    send(mk(32'h5555_AAAB, bit1(25)));
    cfg_detect_en = 1'b1;
    // R2: another coset value
    cfg_coset = 8'hA3;
    send(mk(32'h7777_0000, '0));
    send(mk(32'h7777_0001, bit1(10)));
    send(mk(32'h7777_0002, '0));
    // R1: back-pressure with mixed cells
    bp = 1'b1;
    for (int i = 0; i < 200; i++) begin
      int sel;
      sel = int'($urandom % 4);
      send(mk($urandom, sel == 0 ? '0 : sel == 1 ? bit1(int'($urandom % 40)) : (bit1(1) | bit1(36))));
    end
    bp = 1'b0;
    out_ready = 1'b1;
    // R9: loopback freezes counters
    loopback = 1'b1;
    for (int i = 0; i < 5; i++) send(mk($urandom, bit1(4)));
    loopback = 1'b0;
    // R10: thresholds moved around current counts
    thr_hec = 16'd1000;
    thr_cor = 16'd0;
    idle(2);
    // R9: saturation of the error counter
    cfg_stay_correct = 1'b1;
    for (int i = 0; i < 65600; i++) send(mk(32'h0000_0100 + 32'(i), bit1(0) | bit1(39)));
    idle(4);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL R1 watchdog actual=%0d expected<=150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule